// File: doc/BRIEF.md
# Speed-Loop Phase Comparator with Lock Qualification

This block sits in the digital part of a spindle or polygon motor speed loop. It takes an already synchronized reference clock and a tachometer pulse train (one pulse per revolution slice, taken from a single Hall channel) and compares the rising edges of the two. The phase difference comes out as a pair of pulse-width-coded error lines: "up" is high from a reference edge until the matching tachometer edge, "down" is high from a tachometer edge until the matching reference edge. An external analog error amplifier and loop filter turn these pulses into a torque command; that part is outside this block.

From the same edges the block derives a lock flag. A tachometer period counts as in-phase when the error pulse within it stayed short, and a run of such periods raises an internal lock condition. A mask timer then holds the visible lock output off until the condition has lasted a set number of clock cycles, so that brief lock episodes while the loop hunts do not show. The block also measures both periods in system clock cycles and, when enabled, selects a reduced motor current limit (87.5 % of full) once the motor turns faster than 95 % of the target speed, which softens the final pull-in.

Top module: `fg_phase_lock`

## Requirements
- R1: A rising reference edge with no tachometer edge pending raises `err_up`; it stays high until the next rising tachometer edge, so for edges d cycles apart it is high for exactly d cycles.
- R2: A rising tachometer edge with no reference edge pending raises `err_dn`; it stays high until the next rising reference edge, high for exactly d cycles when the edges are d cycles apart.
- R3: `err_up` and `err_dn` are never high in the same cycle.
- R4: The internal lock condition becomes true on the tachometer edge that closes the LOCK_N-th consecutive period whose accumulated error-pulse count stayed below LOCK_TH, and it drops on the first tachometer edge closing a period at or above LOCK_TH; a run of fewer than LOCK_N good periods never raises it.
- R5: With MASK_CYC greater than zero, `lock_out` rises exactly MASK_CYC cycles after the internal lock condition rises, falls with it, and never shows a lock episode shorter than MASK_CYC cycles.
- R6: With MASK_CYC equal to zero, `lock_out` follows the internal lock condition in the same cycle, i.e. it is high at the first sample after the qualifying tachometer edge.
- R7: `ilim_low` is high only when both the reference and the tachometer period have been captured from two edges since `run_en` rose and 95 x tachometer period < 100 x reference period (strictly faster than 95 % of target; equality gives full limit).
- R8: With `speed_en` low, `ilim_low` is low in the same cycle.
- R9: One cycle after `run_en` is low, `err_up`, `err_dn`, `lock_out` and `ilim_low` are all low and all period, error and lock history is cleared.
- R10: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | Synchronized reference clock (target tachometer rate) |
| fg_in | input | 1 | Synchronized tachometer pulse train |
| run_en | input | 1 | Run enable; low clears all state |
| speed_en | input | 1 | Enables the near-target current-limit reduction |
| err_up | output | 1 | Phase-error pulse, reference leads |
| err_dn | output | 1 | Phase-error pulse, tachometer leads |
| lock_out | output | 1 | Masked lock indication |
| ilim_low | output | 1 | 1 selects the 87.5 % current limit, 0 the full limit |

## Verification
Random pairs of period and edge offset, with either signal leading, check that each error pulse width equals the offset and that the opposite line stays quiet, which separates a correct leading/lagging decision from a swapped or stretched pulse. A steady small-offset train followed by one large-offset period pins the exact lock rise and fall cycles on a masked and an unmasked instance, while trains of good periods broken by bad ones separate the consecutive-period rule (hunting never locks) from the mask rule (short lock seen raw but hidden on the output). Directed period ratios at and around the 95 % boundary, plus random ratios and a single-edge start, tell apart a strict from a non-strict speed comparison and a valid-period guard from its absence.

// File: rtl/fgpl_pkg.sv
package fgpl_pkg;
  // Phase comparator state: which edge opened the pending error pulse
  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_UP   = 2'd1,
    PD_DN   = 2'd2
  } pd_state_e;
endpackage

// File: rtl/fgpl_edge_meter.sv
module fgpl_edge_meter #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             sig_in,
  output logic             edge_o,
  output logic [PER_W-1:0] period_o,
  output logic             valid_o
);
  localparam logic [PER_W-1:0] CNT_MAX = '1;

  logic             sig_q;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [1:0]       seen_q, seen_d;

  assign edge_o   = sig_in & ~sig_q;
  assign period_o = per_q;
  assign valid_o  = (seen_q == 2'd2);

  always_comb begin
    cnt_d  = cnt_q;
    per_d  = per_q;
    seen_d = seen_q;
    if (!run_en) begin
      cnt_d  = '0;
      per_d  = '0;
      seen_d = 2'd0;
    end else if (edge_o) begin
      cnt_d = PER_W'(1);
      per_d = cnt_q;
      if (seen_q != 2'd2) seen_d = seen_q + 2'd1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q  <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
      seen_q <= 2'd0;
    end else begin
      sig_q  <= sig_in;
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/fgpl_phase_det.sv
module fgpl_phase_det
  import fgpl_pkg::*;
#(
  parameter int LOCK_TH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic ref_edge,
  input  logic fg_edge,
  output logic up_o,
  output logic dn_o,
  output logic win_good_o
);
  localparam int              ERR_W   = $clog2(LOCK_TH + 1);
  localparam logic [ERR_W-1:0] ERR_SAT = ERR_W'(LOCK_TH);

  pd_state_e        st_q, st_d;
  logic [ERR_W-1:0] err_q, err_d;

  assign up_o       = (st_q == PD_UP);
  assign dn_o       = (st_q == PD_DN);
  assign win_good_o = fg_edge && (err_q < ERR_SAT);

  always_comb begin
    st_d = st_q;
    if (!run_en) begin
      st_d = PD_IDLE;
    end else begin
      unique case (st_q)
        PD_IDLE: begin
          if (ref_edge && !fg_edge)      st_d = PD_UP;
          else if (fg_edge && !ref_edge) st_d = PD_DN;
        end
        PD_UP:   if (fg_edge)  st_d = ref_edge ? PD_UP : PD_IDLE;
        PD_DN:   if (ref_edge) st_d = fg_edge  ? PD_DN : PD_IDLE;
        default: st_d = PD_IDLE;
      endcase
    end
  end

  // error cycles accumulated over one tachometer period
  always_comb begin
    err_d = err_q;
    if (!run_en || fg_edge)                        err_d = '0;
    else if ((st_q != PD_IDLE) && (err_q != ERR_SAT)) err_d = err_q + ERR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PD_IDLE;
      err_q <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/fgpl_lock_qual.sv
module fgpl_lock_qual #(
  parameter int LOCK_N   = 8,
  parameter int MASK_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic fg_edge,
  input  logic win_good,
  output logic raw_lock_o,
  output logic lock_o
);
  localparam int              RUN_W   = $clog2(LOCK_N + 1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(LOCK_N);

  logic [RUN_W-1:0] run_q, run_d;

  assign raw_lock_o = (run_q == RUN_SAT);

  always_comb begin
    run_d = run_q;
    if (!run_en)              run_d = '0;
    else if (fg_edge) begin
      if (!win_good)          run_d = '0;
      else if (run_q != RUN_SAT) run_d = run_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  generate
    if (MASK_CYC == 0) begin : g_direct
      assign lock_o = raw_lock_o;
    end else begin : g_mask
      localparam int              MSK_W   = $clog2(MASK_CYC + 1);
      localparam logic [MSK_W-1:0] MSK_SAT = MSK_W'(MASK_CYC);
      logic [MSK_W-1:0] msk_q, msk_d;

      always_comb begin
        msk_d = msk_q;
        if (!run_en || !raw_lock_o) msk_d = '0;
        else if (msk_q != MSK_SAT)  msk_d = msk_q + MSK_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) msk_q <= '0;
        else        msk_q <= msk_d;
      end

      assign lock_o = raw_lock_o && (msk_q == MSK_SAT);
    end
  endgenerate
endmodule

// File: rtl/fg_phase_lock.sv
module fg_phase_lock #(
  parameter int MAX_PERIOD = 65535,
  parameter int LOCK_TH    = 64,
  parameter int LOCK_N     = 8,
  parameter int MASK_CYC   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fg_in,
  input  logic run_en,
  input  logic speed_en,
  output logic err_up,
  output logic err_dn,
  output logic lock_out,
  output logic ilim_low
);
  localparam int PER_W = $clog2(MAX_PERIOD + 1);
  localparam int CMP_W = PER_W + 7;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // index 0: reference, index 1: tachometer
  logic [1:0]       sig_vec, edge_vec, valid_vec;
  logic [PER_W-1:0] per_arr [2];
  assign sig_vec = {fg_in, ref_in};

  for (genvar i = 0; i < 2; i++) begin : g_meter
    fgpl_edge_meter #(.PER_W(PER_W)) u_meter (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .run_en   (run_en),
      .sig_in   (sig_vec[i]),
      .edge_o   (edge_vec[i]),
      .period_o (per_arr[i]),
      .valid_o  (valid_vec[i])
    );
  end

  logic win_good;
  logic raw_lock;

  fgpl_phase_det #(.LOCK_TH(LOCK_TH)) u_pd (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .run_en     (run_en),
    .ref_edge   (edge_vec[0]),
    .fg_edge    (edge_vec[1]),
    .up_o       (err_up),
    .dn_o       (err_dn),
    .win_good_o (win_good)
  );

  fgpl_lock_qual #(.LOCK_N(LOCK_N), .MASK_CYC(MASK_CYC)) u_lq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .run_en     (run_en),
    .fg_edge    (edge_vec[1]),
    .win_good   (win_good),
    .raw_lock_o (raw_lock),
    .lock_o     (lock_out)
  );

  // faster than 95 % of target: 95 * T_fg < 100 * T_ref
  logic [CMP_W-1:0] fg_scaled, ref_scaled;
  assign fg_scaled  = CMP_W'(per_arr[1]) * CMP_W'(95);
  assign ref_scaled = CMP_W'(per_arr[0]) * CMP_W'(100);
  assign ilim_low   = speed_en && (&valid_vec) && (fg_scaled < ref_scaled);
endmodule

// File: rtl/fg_phase_lock_chk.sv
module fg_phase_lock_chk #(
  parameter int MASK_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic ref_in,
  input logic fg_in,
  input logic run_en,
  input logic speed_en,
  input logic err_up,
  input logic err_dn,
  input logic lock_out,
  input logic ilim_low,
  input logic raw_lock
);
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_up && err_dn));

  assert_up_from_ref_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_up) |-> $past(ref_in));

  assert_dn_from_fg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_dn) |-> $past(fg_in));

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!err_up && !err_dn && !lock_out && !ilim_low));

  assert_full_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_en |-> !ilim_low);

  generate
    if (MASK_CYC > 0) begin : g_mask_chk
      assert_mask_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_out) |-> $past(raw_lock));
    end
  endgenerate
endmodule

bind fg_phase_lock fg_phase_lock_chk #(.MASK_CYC(MASK_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_in   (ref_in),
  .fg_in    (fg_in),
  .run_en   (run_en),
  .speed_en (speed_en),
  .err_up   (err_up),
  .err_dn   (err_dn),
  .lock_out (lock_out),
  .ilim_low (ilim_low),
  .raw_lock (raw_lock)
);

// File: tb/test_fg_phase_lock.sv
module test_fg_phase_lock;
  localparam int TH   = 8;
  localparam int NL   = 3;
  localparam int MK   = 100;
  localparam int MAXP = 255;

  logic clk = 1'b0;
  logic rst_n, ref_in, fg_in, run_en, speed_en;
  logic up, dn, lk, il;
  logic up_r, dn_r, lk_r, il_r;

  always #2 clk = ~clk;

  fg_phase_lock #(.MAX_PERIOD(MAXP), .LOCK_TH(TH), .LOCK_N(NL), .MASK_CYC(MK)) i_fg_phase_lock (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fg_in(fg_in), .run_en(run_en),
    .speed_en(speed_en), .err_up(up), .err_dn(dn), .lock_out(lk), .ilim_low(il));

  fg_phase_lock #(.MAX_PERIOD(MAXP), .LOCK_TH(TH), .LOCK_N(NL), .MASK_CYC(0)) i_fg_phase_lock_raw (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fg_in(fg_in), .run_en(run_en),
    .speed_en(speed_en), .err_up(up_r), .err_dn(dn_r), .lock_out(lk_r), .ilim_low(il_r));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit lk_hist [1024];
  bit lr_hist [1024];
  int blk_up, blk_dn, fg_rise_cnt, last_fg;
  bit lk_seen, lr_seen;
  logic s_up, s_dn, s_lk, s_il, s_lr;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sample outputs (effect of earlier drives), then drive this cycle's inputs
  task automatic step(input logic r, input logic f);
    @(negedge clk);
    s_up = up; s_dn = dn; s_lk = lk; s_il = il; s_lr = lk_r;
    lk_hist[cyc % 1024] = lk;
    lr_hist[cyc % 1024] = lk_r;
    blk_up += int'(up);
    blk_dn += int'(dn);
    if (lk)   lk_seen = 1'b1;
    if (lk_r) lr_seen = 1'b1;
    ref_in = r;
    fg_in  = f;
    cyc++;
  endtask

  // one period of both signals; the leading one rises at cycle 0, the other at d
  task automatic block(input int p, input int d, input bit lead_ref);
    blk_up = 0;
    blk_dn = 0;
    for (int c = 0; c < p; c++) begin
      logic a = (c < p / 2);
      logic b = (c >= d) && (c < d + p / 2);
      if (lead_ref) begin
        if (c == d) begin last_fg = cyc; fg_rise_cnt++; end
        step(a, b);
      end else begin
        if (c == 0) begin last_fg = cyc; fg_rise_cnt++; end
        step(b, a);
      end
    end
  endtask

  task automatic speed_run(input int pr, input int pf, input int n);
    for (int i = 0; i < n; i++) step((i % pr) < pr / 2, (i % pf) < pf / 2);
  endtask

  function automatic int exp_ilim(input int pr, input int pf, input bit en);
    return (en && (95 * pf < 100 * pr)) ? 1 : 0;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int g3, gb, pr, pf;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ref_in = 1'b0; fg_in = 1'b0; run_en = 1'b0; speed_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 up after reset", int'(up), 0);
    check("R10 dn after reset", int'(dn), 0);
    check("R10 lock after reset", int'(lk), 0);
    check("R10 ilim after reset", int'(il), 0);
    check("R10 raw-instance lock after reset", int'(lk_r), 0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0);
    run_en = 1'b1;

    // R1 / R2 directed corners
    block(40, 1, 1'b1);  check("R1 up width d=1", blk_up, 1);  check("R1 no dn", blk_dn, 0);
    block(40, 19, 1'b1); check("R1 up width d=19", blk_up, 19); check("R1 no dn", blk_dn, 0);
    block(40, 1, 1'b0);  check("R2 dn width d=1", blk_dn, 1);  check("R2 no up", blk_up, 0);
    block(40, 19, 1'b0); check("R2 dn width d=19", blk_dn, 19); check("R2 no up", blk_up, 0);
    // R1 / R2 constrained random
    for (int k = 0; k < 24; k++) begin
      int p = 20 + 2 * int'($urandom % 21);
      int d = 1 + int'($urandom % (p / 2 - 1));
      bit lead = bit'($urandom % 2);
      block(p, d, lead);
      if (lead) begin
        check("R1 up width random", blk_up, d);
        check("R1 dn quiet random", blk_dn, 0);
      end else begin
        check("R2 dn width random", blk_dn, d);
        check("R2 up quiet random", blk_up, 0);
      end
    end

    run_en = 1'b0;
    step(1'b0, 1'b0);
    check("R9 up cleared", int'(s_up), 0);
    check("R9 dn cleared", int'(s_dn), 0);
    step(1'b0, 1'b0);
    run_en = 1'b1;

    // R4 / R5 / R6 lock timing
    fg_rise_cnt = 0;
    g3 = -1;
    for (int b = 0; b < 6; b++) begin
      block(40, 2, 1'b1);
      if (fg_rise_cnt == NL && g3 < 0) g3 = last_fg;
    end
    check("R5 lock hidden at mask end-1", int'(lk_hist[(g3 + MK) % 1024]), 0);
    check("R5 lock shown after mask", int'(lk_hist[(g3 + MK + 1) % 1024]), 1);
    check("R6 raw lock before edge", int'(lr_hist[g3 % 1024]), 0);
    check("R6 raw lock right after edge", int'(lr_hist[(g3 + 1) % 1024]), 1);
    check("R4 lock held in steady train", int'(s_lk), 1);

    block(40, 15, 1'b1);
    gb = last_fg;
    check("R4 lock before bad edge", int'(lk_hist[gb % 1024]), 1);
    check("R4 unlock on first bad period", int'(lk_hist[(gb + 1) % 1024]), 0);
    check("R4 raw lock before bad edge", int'(lr_hist[gb % 1024]), 1);
    check("R4 raw unlock on first bad period", int'(lr_hist[(gb + 1) % 1024]), 0);

    repeat (4) block(40, 2, 1'b1);
    check("R4 relock after good periods", int'(s_lr), 1);
    run_en = 1'b0;
    step(1'b0, 1'b0);
    check("R9 lock cleared by run_en low", int'(s_lr), 0);
    run_en = 1'b1;

    // R4 hunting: never NL good periods in a row
    lk_seen = 1'b0; lr_seen = 1'b0;
    repeat (3) begin
      block(40, 2, 1'b1); block(40, 2, 1'b1); block(40, 15, 1'b1);
    end
    check("R4 no lock while hunting", int'(lr_seen), 0);
    check("R4 no masked lock while hunting", int'(lk_seen), 0);

    // R5 short lock episodes hidden by the mask
    lk_seen = 1'b0; lr_seen = 1'b0;
    repeat (2) begin
      block(40, 2, 1'b1); block(40, 2, 1'b1); block(40, 2, 1'b1); block(40, 15, 1'b1);
    end
    check("R5 short lock masked", int'(lk_seen), 0);
    check("R6 short lock visible unmasked", int'(lr_seen), 1);

    // R7 / R8 speed check
    speed_en = 1'b1;
    run_en = 1'b0;
    step(1'b0, 1'b0);
    run_en = 1'b1;
    speed_run(40, 40, 30);
    check("R7 no reduction before two edges", int'(s_il), 0);
    speed_run(40, 40, 150);
    check("R7 at target", int'(s_il), exp_ilim(40, 40, 1'b1));
    speed_en = 1'b0;
    step(1'b0, 1'b0);
    check("R8 speed_en low gives full limit", int'(s_il), 0);
    speed_en = 1'b1;
    speed_run(95, 100, 400);
    check("R7 exactly 95 percent is not above", int'(s_il), exp_ilim(95, 100, 1'b1));
    speed_run(95, 99, 400);
    check("R7 just above 95 percent", int'(s_il), exp_ilim(95, 99, 1'b1));
    speed_run(40, 60, 300);
    check("R7 slow motor", int'(s_il), exp_ilim(40, 60, 1'b1));
    for (int k = 0; k < 12; k++) begin
      pr = 30 + int'($urandom % 71);
      pf = 30 + int'($urandom % 91);
      speed_run(pr, pf, 3 * max2(pr, pf) + 10);
      check("R7 random ratio", int'(s_il), exp_ilim(pr, pf, 1'b1));
    end

    speed_run(50, 45, 200);
    check("R7 fast motor", int'(s_il), 1);
    run_en = 1'b0;
    step(1'b0, 1'b0);
    check("R9 ilim cleared by run_en low", int'(s_il), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule